// File: doc/BRIEF.md
# Serial Clock Stop Controller

This block lets a controller switch twelve clock outputs on and off one by one, without runt pulses. It receives a short serial frame on a data line, timed by its own free-running serial clock. Each frame opens with a low start bit and is followed by twelve enable bits. The enable bits are collected in a shift register. Only when the twelfth bit has arrived are they copied, all together, into an active enable register. Each active bit then enters the clock domain of its own output through a two-flop synchronizer. There it is captured on the falling edge of that output's clock. The output is the input clock ANDed with the captured bit, so an output can start or stop only while its clock is low.

The receiver is a two-state machine. RX_IDLE waits for a start bit. Its "line idle" transition stays in RX_IDLE while the data line is high. Its "start seen" transition moves to RX_SHIFT when a low bit is sampled. RX_SHIFT gathers data bits. Its "collect" transition stays in RX_SHIFT for bits one to eleven. Its "frame done" transition returns to RX_IDLE on the twelfth bit, and the active register is loaded on that same edge. Two further clock outputs exist in the wider system, one of them the feedback clock. They are not routed through this block, so they can never be stopped.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset, all active enable bits are 1, so every `clk_out[i]` follows `clk_in[i]`.
- R2: In RX_IDLE, a 0 sampled on `ser_din` at a rising edge of `ser_clk` starts a frame (RX_SHIFT). A 1 keeps the receiver in RX_IDLE.
- R3: Data bits are sampled on the rising `ser_clk` edges after the start bit. The k-th bit sent (k = 0..11) controls `clk_out[k]`. The index order is A0, A1, A2, A3, B0, B1, B2, B3, C1, C2, C3, then the sync output.
- R4: An enable bit of 0 holds its output at 0. An enable bit of 1 makes the output follow its input clock.
- R5: The active enable register changes only on the edge that samples the twelfth data bit. A partly received frame leaves every output unchanged.
- R6: After the twelfth bit the receiver is back in RX_IDLE. A new start bit may follow on the very next `ser_clk` edge.
- R7: Every high pulse on `clk_out[i]` covers a whole high phase of `clk_in[i]`. An enable change takes effect only while `clk_in[i]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ser_din | input | 1 | Serial frame data; held high when idle |
| clk_in | input | 12 | Clocks to be gated, one per output |
| clk_out | output | 12 | Gated clocks, index order as in R3 |

## Verification
The properties assume that `ser_din` holds a known value at each rising edge of `ser_clk` and that reset is released while the serial clock is running. The bench changes `ser_din` only on falling edges of `ser_clk`. Its `clk_in` clocks change state only on whole nanoseconds, and it samples the outputs at fractional times, so the data and the gated clocks are never compared at an edge. Between frames the bench waits several periods of the slowest input clock, which covers the synchronizer delay.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic {
        RX_IDLE,
        RX_SHIFT
    } rx_state_t;
endpackage

// File: rtl/clkstop_rx.sv
module clkstop_rx
    import clkstop_pkg::*;
#(
    parameter int N  = 12,
    parameter int CW = $clog2(N)
) (
    input  logic          ser_clk,
    input  logic          rst_n,
    input  logic          ser_din,
    output rx_state_t     state_o,
    output logic [CW-1:0] cnt_o,
    output logic [N-1:0]  en_o
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    rx_state_t      state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [N-1:0]   shreg_q;
    logic [N-1:0]   en_q;
    logic           last_bit;

    assign last_bit = (cnt_q == LAST);

    // state register
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!ser_din) state_d = RX_SHIFT;   // start seen
            RX_SHIFT: if (last_bit) state_d = RX_IDLE;    // frame done
            default:  state_d = RX_IDLE;
        endcase
    end

    // outputs: bit counter, shift register, active enables
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '1;
            en_q    <= '1;
        end else begin
            unique case (state_q)
                RX_IDLE: cnt_q <= '0;
                RX_SHIFT: begin
                    shreg_q <= {ser_din, shreg_q[N-1:1]};
                    if (last_bit) begin
                        cnt_q <= '0;
                        en_q  <= {ser_din, shreg_q[N-1:1]};
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
    assign en_o    = en_q;
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en_async,
    output logic clk_out
);
    logic sync1_q, sync2_q, en_low_q;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= en_async;
            sync2_q <= sync1_q;
        end
    end

    // captured as the clock goes low, so the gate only moves in the low phase
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) en_low_q <= 1'b1;
        else        en_low_q <= sync2_q;
    end

    assign clk_out = clk_in & en_low_q;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N = 12
) (
    input  logic         ser_clk,
    input  logic         rst_n,
    input  logic         ser_din,
    input  logic [N-1:0] clk_in,
    output logic [N-1:0] clk_out
);
    localparam int CW = $clog2(N);

    rx_state_t     rx_state;
    logic [CW-1:0] rx_cnt;
    logic [N-1:0]  en_act;

    clkstop_rx #(.N(N), .CW(CW)) u_rx (
        .ser_clk (ser_clk),
        .rst_n   (rst_n),
        .ser_din (ser_din),
        .state_o (rx_state),
        .cnt_o   (rx_cnt),
        .en_o    (en_act)
    );

    for (genvar g = 0; g < N; g++) begin : g_gate
        clkstop_gate u_gate (
            .clk_in   (clk_in[g]),
            .rst_n    (rst_n),
            .en_async (en_act[g]),
            .clk_out  (clk_out[g])
        );
    end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk
    import clkstop_pkg::*;
#(
    parameter int N  = 12,
    parameter int CW = $clog2(N)
) (
    input logic          ser_clk,
    input logic          rst_n,
    input logic          ser_din,
    input rx_state_t     rx_state,
    input logic [CW-1:0] rx_cnt,
    input logic [N-1:0]  en_act
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    a_r2_start_seen: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (rx_state == RX_IDLE && !ser_din) |=> rx_state == RX_SHIFT);

    a_r2_line_idle: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (rx_state == RX_IDLE && ser_din) |=> rx_state == RX_IDLE);

    a_r5_no_partial_load: assert property (@(posedge ser_clk) disable iff (!rst_n)
        !(rx_state == RX_SHIFT && rx_cnt == LAST) |=> $stable(en_act));

    a_r6_frame_done: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (rx_state == RX_SHIFT && rx_cnt == LAST) |=> rx_state == RX_IDLE);

    a_r6_count_bound: assert property (@(posedge ser_clk) disable iff (!rst_n)
        rx_cnt <= LAST);

    a_r1_reset_enables: assert property (@(posedge ser_clk) disable iff (!rst_n)
        $rose(rst_n) |-> &en_act);
endmodule

bind clkstop_ctrl clkstop_chk #(.N(N)) u_chk (
    .ser_clk  (ser_clk),
    .rst_n    (rst_n),
    .ser_din  (ser_din),
    .rx_state (rx_state),
    .rx_cnt   (rx_cnt),
    .en_act   (en_act)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/100ps
module sim_clkstop_ctrl;
    localparam int N = 12;
    localparam int NPAT = 6;
    localparam logic [N-1:0] PAT [NPAT] = '{12'h000, 12'h001, 12'h800,
                                            12'hA5A, 12'h3C3, 12'hFFF};

    logic         ser_clk = 1'b0;
    logic         run = 1'b1;
    logic         rst_n = 1'b0;
    logic         ser_din = 1'b1;
    logic [N-1:0] clk_in;
    logic [N-1:0] clk_out;
    int           checks = 0;
    int           fails = 0;
    bit           done = 1'b0;

    clkstop_ctrl #(.N(N)) u0 (
        .ser_clk (ser_clk),
        .rst_n   (rst_n),
        .ser_din (ser_din),
        .clk_in  (clk_in),
        .clk_out (clk_out)
    );

    // 200 MHz serial clock, stoppable for the partial-frame test
    initial forever begin
        #2.5;
        if (run) ser_clk = ~ser_clk;
    end

    // output clocks: half period 7+i ns, edges on whole ns
    for (genvar gi = 0; gi < N; gi++) begin : g_clk
        localparam int HP = 7 + gi;
        logic c = 1'b0;
        longint t_rise = -1;
        initial forever #(HP) c = ~c;
        assign clk_in[gi] = c;
        // R7: every high pulse on an output spans a full input high phase
        always @(posedge clk_out[gi]) t_rise = $time;
        always @(negedge clk_out[gi]) begin
            if (rst_n && t_rise >= 0) begin
                checks++;
                if ($time - t_rise != HP) begin
                    fails++;
                    $display("FAIL R7 out%0d pulse width actual=%0d expected=%0d",
                             gi, $time - t_rise, HP);
                end
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge ser_clk);
        ser_din = b;
    endtask

    task automatic send_frame(input logic [N-1:0] v);
        send_bit(1'b0);
        for (int k = 0; k < N; k++) send_bit(v[k]);
        send_bit(1'b1);
    endtask

    // wait for synchronizers, then compare each output over a window
    task automatic check_window(input logic [N-1:0] exp, input string tag);
        int bad [N];
        #200.3;
        for (int i = 0; i < N; i++) bad[i] = 0;
        for (int s = 0; s < 160; s++) begin
            for (int i = 0; i < N; i++)
                if (clk_out[i] !== (clk_in[i] & exp[i])) bad[i]++;
            #1;
        end
        for (int i = 0; i < N; i++) begin
            checks++;
            if (bad[i] != 0) begin
                fails++;
                $display("FAIL %s out%0d actual_mismatches=%0d expected_en=%0b",
                         tag, i, bad[i], exp[i]);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #40.3;
        rst_n = 1'b1;
        // R1: reset state, all outputs running
        check_window('1, "R1");
        // R2: idle line high for a while, nothing changes
        repeat (20) send_bit(1'b1);
        check_window('1, "R2");
        // R3/R4 table: mapping and stop/run values
        for (int p = 0; p < NPAT; p++) begin
            send_frame(PAT[p]);
            check_window(PAT[p], "R3_R4");
        end
        // R5: partial frame with serial clock paused leaves outputs unchanged
        send_frame(12'hFFF);
        check_window(12'hFFF, "R4");
        send_bit(1'b0);
        for (int k = 0; k < 6; k++) send_bit(1'b0);
        run = 1'b0;
        check_window(12'hFFF, "R5");
        run = 1'b1;
        for (int k = 6; k < N; k++) send_bit(k[0]);
        send_bit(1'b1);
        check_window(12'hA80, "R5");
        // R6: back-to-back frames, the second one wins
        send_bit(1'b0);
        for (int k = 0; k < N; k++) send_bit(1'b0);
        send_bit(1'b0);
        for (int k = 0; k < N; k++) send_bit(k < 6);
        send_bit(1'b1);
        check_window(12'h03F, "R6");
        // R1: reset in mid-run restores all enables
        send_frame(12'h000);
        check_window(12'h000, "R4");
        @(negedge clk_in[0]);
        #0.3;
        rst_n = 1'b0;
        #20;
        rst_n = 1'b1;
        check_window('1, "R1");
        finish_run();
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        finish_run();
    end
endmodule